// File: doc/BRIEF.md
# Sampling converter strobe and readout controller

This block is the digital control front end of a 12-bit sampling analog-to-digital converter. It takes a read/convert strobe, an active-low chip select and a mode select. From these it issues one-cycle start requests to a successive-approximation core, reports conversion progress on an active-low BUSY flag, and presents the last result on a 12-bit parallel bus whose pad tri-state is controlled by a drive-enable output.

Two strobe modes are supported. In convert mode the strobe idles high, and a low pulse launches a conversion. In read mode the strobe idles low. A high pulse first exposes the result of the previous conversion, and the falling edge of that pulse launches the next one. The strobe is synchronised into the system clock and filtered against a minimum width. During a conversion all strobe activity is discarded and the bus is released. The core returns a one-cycle done pulse with the result. The output latch loads on that pulse and tracking resumes at once. BUSY returns high one cycle later, so its rising edge can be used as a data-ready strobe.

Top module: `samp_adc_ctrl`

## Requirements
- R1: After reset, busy_o is 1, start_o is 0, hold_o is 0, data_oe_o is 0 and data_o is 0.
- R2: With mode_i = 0 (convert mode), a low level on rc_i lasting at least MIN_W clock cycles (default 3) produces exactly one start_o pulse, followed by hold_o = 1 and busy_o = 0. A low level of fewer than MIN_W cycles starts nothing.
- R3: With mode_i = 1 (read mode), a high level on rc_i of at least MIN_W cycles followed by a falling edge produces exactly one start. A shorter high pulse starts nothing. While rc_i is high, the bus shows the result of the previous conversion. After any change of mode_i, no start occurs until rc_i has been seen at the new mode's idle level (high in convert mode, low in read mode).
- R4: While busy_o is 0, strobe edges and pulses are ignored, and no second start occurs. After a conversion, no new start occurs until rc_i has been seen at the idle level of the current mode, so a strobe held active through a conversion never retriggers.
- R5: A done_i pulse during a conversion loads result_i into the output latch and drops hold_o at the same clock edge. busy_o stays 0 for that cycle and rises on the next edge. After the rise, the bus shows the loaded value when it is enabled.
- R6: data_oe_o is 1 only when cs_ni = 0, busy_o = 1 and the synchronised rc_i is high. When enabled, data_o equals the latch; otherwise data_o is 0.
- R7: start_o is never high for two consecutive cycles, and it is high only in a cycle that follows an idle cycle.
- R8: A done_i pulse while no conversion is in progress has no effect: the latch and busy_o stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rc_i | input | 1 | Read/convert strobe, asynchronous |
| cs_ni | input | 1 | Chip select, active low, gates the bus drive |
| mode_i | input | 1 | 0 = convert mode, 1 = read mode |
| done_i | input | 1 | One-cycle conversion-complete pulse from the core |
| result_i | input | 12 | Conversion result from the core, bit 11 is the MSB |
| start_o | output | 1 | One-cycle start request to the core |
| hold_o | output | 1 | 1 while the sample is held, 0 while tracking |
| busy_o | output | 1 | 0 while a conversion is in progress |
| data_o | output | 12 | Latched result when driven, 0 otherwise |
| data_oe_o | output | 1 | Pad drive enable for data_o |

## Verification
The hardest states to reach are the ones where the strobe and a conversion overlap. These are a second full-width pulse that lies entirely inside a conversion, and a strobe held active from before the start until well after BUSY has risen. The bench builds both by waiting for busy_o to fall before shaping the next pulse. It uses a core latency long enough that the whole synchronised pulse falls inside the conversion, and it counts start pulses across the whole window and the idle time after it. Mode switches are made with the strobe at the old mode's idle level, to check that the switch itself launches nothing. A done pulse is injected while idle to show that the latch keeps the last value.

// File: rtl/samp_adc_pkg.sv
package samp_adc_pkg;
  localparam int unsigned DATA_W = 12;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_FIN  = 2'd2
  } seq_state_e;

  typedef enum logic {
    MODE_CONVERT = 1'b0,
    MODE_READ    = 1'b1
  } strobe_mode_e;
endpackage

// File: rtl/samp_adc_sync.sv
module samp_adc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[i] <= RST_VAL;
        else         sr_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[i] <= RST_VAL;
        else         sr_q[i] <= sr_q[i-1];
      end
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/samp_adc_strobe.sv
module samp_adc_strobe
  import samp_adc_pkg::*;
#(
  parameter int unsigned MIN_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rc_s_i,
  input  logic mode_i,
  input  logic idle_i,
  output logic fire_o
);
  localparam int unsigned CNT_W = $clog2(MIN_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_W);
  localparam logic [CNT_W-1:0] CNT_CV  = CNT_W'(MIN_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rc_prev_q;
  logic             blk_q;
  logic             mode_q;
  logic             act;
  logic             fire_cv, fire_rd;
  logic             mode_chg;

  // active level: low in convert mode, high in read mode
  assign act      = (mode_i == MODE_READ) ? rc_s_i : ~rc_s_i;
  assign mode_chg = (mode_i != mode_q);

  assign fire_cv = (mode_i == MODE_CONVERT) && idle_i && !blk_q && !mode_chg &&
                   !rc_s_i && (cnt_q == CNT_CV);
  assign fire_rd = (mode_i == MODE_READ) && idle_i && !blk_q && !mode_chg &&
                   rc_prev_q && !rc_s_i && (cnt_q == CNT_MAX);
  assign fire_o  = fire_cv | fire_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rc_prev_q <= 1'b1;
      blk_q     <= 1'b1;
      mode_q    <= MODE_CONVERT;
    end else begin
      rc_prev_q <= rc_s_i;
      mode_q    <= mode_i;
      if (fire_o || mode_chg)      blk_q <= 1'b1;
      else if (idle_i && !act)     blk_q <= 1'b0;
      if (!idle_i || !act || blk_q || mode_chg) cnt_q <= '0;
      else if (cnt_q != CNT_MAX)                cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_FIRE_CLEAN_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o); // R4
endmodule

// File: rtl/samp_adc_seq.sv
module samp_adc_seq
  import samp_adc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic done_i,
  output logic start_o,
  output logic hold_o,
  output logic busy_o,
  output logic load_o
);
  seq_state_e state_q, state_d;
  logic       start_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (fire_i) state_d = SEQ_CONV;
      SEQ_CONV: if (done_i) state_d = SEQ_FIN;
      SEQ_FIN:  state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= (state_q == SEQ_IDLE) && fire_i;
    end
  end

  assign start_o = start_q;
  assign hold_o  = (state_q == SEQ_CONV);
  assign busy_o  = (state_q == SEQ_IDLE);
  assign load_o  = (state_q == SEQ_CONV) && done_i;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R7
  AST_START_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(busy_o)); // R7
  AST_BUSY_RISE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(done_i, 2) && $past(hold_o, 2) && !$past(hold_o))); // R5
endmodule

// File: rtl/samp_adc_outlat.sv
module samp_adc_outlat
  import samp_adc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              cs_ni,
  input  logic              busy_i,
  input  logic              rd_lvl_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (load_i) data_q <= result_i;
  end

  // same read level in both modes: convert idles high, read pulses high
  assign data_oe_o = !cs_ni && busy_i && rd_lvl_i;
  assign data_o    = data_oe_o ? data_q : '0;
endmodule

// File: rtl/samp_adc_ctrl.sv
module samp_adc_ctrl
  import samp_adc_pkg::*;
#(
  parameter int unsigned MIN_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rc_i,
  input  logic              cs_ni,
  input  logic              mode_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              start_o,
  output logic              hold_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic rc_s;
  logic fire;
  logic load;

  samp_adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rc_i),
    .q_o   (rc_s)
  );

  samp_adc_strobe #(.MIN_W(MIN_W)) u_strobe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rc_s_i(rc_s),
    .mode_i(mode_i),
    .idle_i(busy_o),
    .fire_o(fire)
  );

  samp_adc_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .done_i (done_i),
    .start_o(start_o),
    .hold_o (hold_o),
    .busy_o (busy_o),
    .load_o (load)
  );

  samp_adc_outlat u_outlat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .result_i (result_i),
    .cs_ni    (cs_ni),
    .busy_i   (busy_o),
    .rd_lvl_i (rc_s),
    .data_o   (data_o),
    .data_oe_o(data_oe_o)
  );

  AST_NO_START_IN_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_o) |-> !start_o); // R4
  AST_BUS_OFF_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !data_oe_o); // R6
  AST_IDLE_DONE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fire) |=> busy_o); // R8
endmodule

// File: tb/samp_adc_ctrl_test.sv
module samp_adc_ctrl_test;
  localparam int LAT = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rc = 1'b1;
  logic        cs_n = 1'b1;
  logic        mode = 1'b0;
  logic        done = 1'b0;
  logic [11:0] result = '0;
  logic        start_o, hold_o, busy_o, data_oe_o;
  logic [11:0] data_o;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int mon_mode = 0;   // 0 none, 1 expect bus driven, 2 expect bus off
  int chk_fin = 0;
  bit inj_req = 0;
  bit inj_act = 0;
  bit finished = 0;
  logic [11:0] last_exp = '0;
  logic [11:0] exp_q[$];

  always #4 clk = ~clk;

  samp_adc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .rc_i(rc), .cs_ni(cs_n), .mode_i(mode),
    .done_i(done), .result_i(result), .start_o(start_o), .hold_o(hold_o),
    .busy_o(busy_o), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_conv();
    int n = 0;
    while (busy_o && n < 40) begin cyc(1); n++; end
    while (!busy_o && n < 80) begin cyc(1); n++; end
    check(n < 80, "R5 conversion end", 32'(n), 32'd80);
  endtask

  // core model and done timing: pushes expected latch values
  initial begin
    logic [11:0] val = 12'hF0F;
    int lat_cnt = -1;
    forever begin
      @(negedge clk);
      if (chk_fin == 1) begin
        check(busy_o == 1'b1, "R5 busy rises one cycle after done", 32'(busy_o), 32'd1);
        chk_fin = 0;
      end
      if (done) begin
        done = 1'b0;
        if (!inj_act) begin
          check(!hold_o && !busy_o, "R5 hold drops at done, busy still low",
                {hold_o, busy_o}, 32'd0);
          chk_fin = 1;
        end
        inj_act = 0;
      end
      if (inj_req) begin
        inj_req = 0; inj_act = 1; done = 1'b1; result = 12'h123;
      end else if (start_o) begin
        lat_cnt = LAT;
      end else if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          done = 1'b1; result = val; exp_q.push_back(val);
          val = val + 12'h3C7; lat_cnt = -1;
        end
      end
    end
  end

  // monitor: start pulses and scoreboard at busy rise
  initial begin
    logic start_prev = 1'b0;
    logic busy_prev = 1'b1;
    forever begin
      @(negedge clk);
      if (start_o) begin
        starts++;
        check(!start_prev, "R7 start one cycle", 32'd1, 32'd0);
      end
      start_prev = start_o;
      if (rst_n && busy_o && !busy_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 busy rise without expected result", 32'd0, 32'd1);
        end else begin
          last_exp = exp_q.pop_front();
          if (mon_mode == 1)
            check(data_oe_o && data_o == last_exp, "R5 latch shown after busy rise",
                  {data_oe_o, data_o}, {1'b1, last_exp});
          else if (mon_mode == 2)
            check(!data_oe_o && data_o == 12'h0, "R6 bus off", {data_oe_o, data_o}, 32'd0);
        end
      end
      busy_prev = busy_o;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    cyc(4);
    check(busy_o && !start_o && !hold_o && !data_oe_o && data_o == 0, "R1 reset state",
          {busy_o, start_o, hold_o, data_oe_o, data_o}, 32'h8000);
    rst_n = 1'b1;
    cyc(4);

    // convert mode, full-width pulse
    cs_n = 1'b0; mon_mode = 1;
    rc = 1'b0; cyc(4); rc = 1'b1;
    cyc(3);
    check(!busy_o && hold_o, "R2 conversion in progress", {busy_o, hold_o}, 32'd1);
    check(!data_oe_o, "R6 bus off during conversion", 32'(data_oe_o), 32'd0);
    wait_conv(); cyc(3);
    check(starts == 1, "R2 one start", 32'(starts), 32'd1);
    check(data_oe_o && data_o == last_exp, "R6 idle read convert mode", 32'(data_o), 32'(last_exp));

    // boundary: exactly MIN_W
    s0 = starts;
    rc = 1'b0; cyc(3); rc = 1'b1;
    wait_conv(); cyc(3);
    check(starts == s0 + 1, "R2 pulse of MIN_W starts", 32'(starts - s0), 32'd1);

    // short pulse ignored
    s0 = starts;
    rc = 1'b0; cyc(2); rc = 1'b1; cyc(12);
    check(starts == s0 && busy_o, "R2 short pulse ignored", 32'(starts - s0), 32'd0);

    // pulse inside conversion ignored
    s0 = starts;
    rc = 1'b0; cyc(4); rc = 1'b1;
    while (busy_o) cyc(1);
    cyc(1);
    rc = 1'b0; cyc(4); rc = 1'b1;
    wait_conv(); cyc(10);
    check(starts == s0 + 1, "R4 pulse during conversion ignored", 32'(starts - s0), 32'd1);

    // strobe held active through conversion
    s0 = starts; mon_mode = 0;
    rc = 1'b0;
    wait_conv(); cyc(8);
    check(starts == s0 + 1 && busy_o, "R4 held strobe no retrigger", 32'(starts - s0), 32'd1);
    rc = 1'b1; cyc(8);
    check(starts == s0 + 1, "R4 release after hold no start", 32'(starts - s0), 32'd1);

    // chip select off
    s0 = starts; cs_n = 1'b1; mon_mode = 2;
    rc = 1'b0; cyc(4); rc = 1'b1;
    wait_conv(); cyc(3);
    check(!data_oe_o && data_o == 0, "R6 no drive without chip select", 32'(data_oe_o), 32'd0);

    // switch to read mode while strobe high
    cs_n = 1'b0; s0 = starts;
    mode = 1'b1; cyc(3); rc = 1'b0; cyc(8);
    check(starts == s0, "R3 mode switch starts nothing", 32'(starts - s0), 32'd0);

    // read mode pulse: shows previous then starts
    rc = 1'b1; cyc(4);
    check(data_oe_o && data_o == last_exp, "R3 read shows previous result", 32'(data_o), 32'(last_exp));
    rc = 1'b0;
    wait_conv(); cyc(3);
    check(starts == s0 + 1, "R3 falling edge starts", 32'(starts - s0), 32'd1);
    check(!data_oe_o, "R6 bus off with strobe low", 32'(data_oe_o), 32'd0);
    rc = 1'b1; cyc(4);
    check(data_oe_o && data_o == last_exp, "R3 second read shows new result", 32'(data_o), 32'(last_exp));
    rc = 1'b0;
    wait_conv(); cyc(3);

    // read mode short pulse
    s0 = starts;
    rc = 1'b1; cyc(2); rc = 1'b0; cyc(12);
    check(starts == s0 && busy_o, "R3 short high pulse ignored", 32'(starts - s0), 32'd0);

    // back to convert mode with strobe low
    mode = 1'b0; cyc(3); rc = 1'b1; cyc(8);
    check(starts == s0, "R3 switch to convert starts nothing", 32'(starts - s0), 32'd0);

    // done while idle
    inj_req = 1; cyc(5);
    check(busy_o && data_oe_o && data_o == last_exp, "R8 idle done ignored",
          32'(data_o), 32'(last_exp));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule